// File: doc/BRIEF.md
# ADC-to-Memory Capture Streamer

This block sits in front of a memory write port. It chooses, cycle by cycle, who drives that port. In the normal case a general data source owns the port and its write strobe, address and data pass straight through. When the route bit of a small control register is set, the port is taken over by a capture engine instead. The engine streams samples from one ADC channel into a fixed window of memory.

Software sets the route bit and a channel-enable bit, supplies a first and a last address, and pulses an arm input. The engine then writes one sample for every ADC valid strobe, at consecutive addresses. It stops by itself once the last address has been written and flags that cycle with a done pulse.

A few samples at either edge of the window may be stale, because of upstream pipeline delay. This is accepted behaviour and is left to the reader of the memory.

Top module: `capstr_top`

## Requirements
- R1: After power-up reset, all control bits are 0, `cap_busy` is 0, `cap_done` is 0, and the memory port mirrors the normal source.
- R2: While the route bit (bit 0 of the control word) is 0, `mem_we`, `mem_addr` and `mem_wdata` equal `norm_we`, `norm_addr` and `norm_wdata` in the same cycle.
- R3: With route set and only the channel-1 bit (bit 8) set, each cycle with `cap_busy` and `adc_vld` high drives `mem_we` high with `mem_wdata` equal to `adc1_data` in that cycle.
- R4: With route set and only the channel-2 bit (bit 9) set, captured data comes from `adc2_data`.
- R5: With both channel bits set, channel 1 is the one captured.
- R6: With route set and neither channel bit set, `mem_we` stays 0 and the capture stays pending, without moving its address.
- R7: `start_addr` and `end_addr` are sampled on the arm cycle. The first write goes to the start address, and each later write goes to the previous address plus one, modulo 2^AW.
- R8: `cap_done` is high in exactly the cycle the end address is written. From the next cycle on, `cap_busy` is 0 and no further capture write happens. The write count is ((end-start) mod 2^AW)+1.
- R9: An arm pulse while a capture is busy is ignored: the address sequence, the end point and the captured data continue unchanged.
- R10: A high `soft_rst` at a clock edge clears all control bits and cancels a running capture, so the port returns to the normal source.
- R11: A cycle without `adc_vld` during a capture produces no write and no done, and leaves the next address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the ADC sample clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| ovr_we | input | 1 | Control word write strobe |
| ovr_wdata | input | 10 | Control word: bit 0 route, bit 8 channel 1, bit 9 channel 2 |
| cap_arm | input | 1 | Arm pulse that starts a capture |
| start_addr | input | AW | First address of the window |
| end_addr | input | AW | Last address of the window |
| adc_vld | input | 1 | One ADC sample available this cycle |
| adc1_data | input | DW | Channel 1 sample |
| adc2_data | input | DW | Channel 2 sample |
| norm_we | input | 1 | Normal source write strobe |
| norm_addr | input | AW | Normal source address |
| norm_wdata | input | DW | Normal source data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| cap_busy | output | 1 | Capture armed and not yet finished |
| cap_done | output | 1 | Final address written this cycle |

## Verification
Two pairs of functions can meet in one cycle. The first is the final write and the done pulse. The bench counts writes against the expected window length and requires `cap_done` on the last write and only there, for many start points, including windows that wrap past the top of the address space and a window of full length. The second pair is a write and a fresh arm pulse: the bench re-arms in the middle of a capture, with a different start address on the inputs, and checks that the address and data sequence does not change.

// File: rtl/capstr_pkg.sv
package capstr_pkg;

  localparam int OVR_W     = 10;
  localparam int BIT_ROUTE = 0;
  localparam int BIT_CH1   = 8;
  localparam int BIT_CH2   = 9;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CH1  = 2'd1,
    SRC_CH2  = 2'd2
  } src_e;

  typedef struct packed {
    logic route;
    logic ch1;
    logic ch2;
  } ovr_t;

  // channel 1 wins when both are enabled
  function automatic src_e pick_src(input logic c1, input logic c2);
    if (c1)      return SRC_CH1;
    else if (c2) return SRC_CH2;
    else         return SRC_NONE;
  endfunction

endpackage

// File: rtl/capstr_ovr_reg.sv
module capstr_ovr_reg
  import capstr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             we,
  input  logic [OVR_W-1:0] wdata,
  output ovr_t             cfg
);

  ovr_t cfg_q;
  logic unused_bits;

  assign unused_bits = ^wdata[BIT_CH1-1:BIT_ROUTE+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (soft_rst) cfg_q <= '0;
    else if (we) begin
      cfg_q.route <= wdata[BIT_ROUTE];
      cfg_q.ch1   <= wdata[BIT_CH1];
      cfg_q.ch2   <= wdata[BIT_CH2];
    end
  end

  assign cfg = cfg_q;

  // R10: soft reset leaves every control bit cleared
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg == '0));

endmodule

// File: rtl/capstr_src_sel.sv
module capstr_src_sel
  import capstr_pkg::*;
#(
  parameter int DW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  ovr_t          cfg,
  input  logic [DW-1:0] adc1,
  input  logic [DW-1:0] adc2,
  output src_e          src,
  output logic          any_ch,
  output logic [DW-1:0] sample
);

  assign src    = pick_src(cfg.ch1, cfg.ch2);
  assign any_ch = (src != SRC_NONE);

  always_comb begin
    case (src)
      SRC_CH1: sample = adc1;
      SRC_CH2: sample = adc2;
      default: sample = '0;
    endcase
  end

  // R5: with channel 1 enabled the sample always follows channel 1 input
  a_r5_ch1_priority: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.ch1 |-> (sample == adc1));

  // R4: channel 2 alone feeds channel 2 input
  a_r4_ch2_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ch2 && !cfg.ch1) |-> (sample == adc2));

endmodule

// File: rtl/capstr_addr_gen.sv
module capstr_addr_gen #(
  parameter int AW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          arm,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic          fire,
  output logic          busy,
  output logic [AW-1:0] ptr,
  output logic          last
);

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic is_final(input logic [AW-1:0] a, input logic [AW-1:0] e);
    return a == e;
  endfunction

  logic [AW-1:0] ptr_q, end_q;
  logic          busy_q;
  logic          arm_take;

  assign arm_take = arm && !busy_q;
  assign last     = fire && busy_q && is_final(ptr_q, end_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      end_q  <= '0;
    end else if (soft_rst) begin
      busy_q <= 1'b0;
    end else if (arm_take) begin
      busy_q <= 1'b1;
      ptr_q  <= start_addr;
      end_q  <= end_addr;
    end else if (fire && busy_q) begin
      if (last) busy_q <= 1'b0;
      else      ptr_q  <= addr_after(ptr_q);
    end
  end

  assign busy = busy_q;
  assign ptr  = ptr_q;

  // R8: a finishing write drops busy on the next edge
  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  // R7: a non-final write advances the address by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy && !last && !soft_rst) |=> (ptr == addr_after($past(ptr))));

  // R11: without a write the address holds during a capture
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire && !soft_rst) |=> $stable(ptr));

  // R9: arming while busy changes neither busy nor the address
  a_r9_rearm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arm && !fire && !soft_rst) |=> (busy && $stable(ptr)));

endmodule

// File: rtl/capstr_top.sv
module capstr_top
  import capstr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             ovr_we,
  input  logic [OVR_W-1:0] ovr_wdata,
  input  logic             cap_arm,
  input  logic [AW-1:0]    start_addr,
  input  logic [AW-1:0]    end_addr,
  input  logic             adc_vld,
  input  logic [DW-1:0]    adc1_data,
  input  logic [DW-1:0]    adc2_data,
  input  logic             norm_we,
  input  logic [AW-1:0]    norm_addr,
  input  logic [DW-1:0]    norm_wdata,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             cap_busy,
  output logic             cap_done
);

  ovr_t          cfg;
  src_e          src;
  logic          any_ch;
  logic [DW-1:0] sample;
  logic          busy;
  logic [AW-1:0] ptr;
  logic          last;
  logic          cap_fire;

  capstr_ovr_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .we       (ovr_we),
    .wdata    (ovr_wdata),
    .cfg      (cfg)
  );

  capstr_src_sel #(.DW(DW)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg),
    .adc1   (adc1_data),
    .adc2   (adc2_data),
    .src    (src),
    .any_ch (any_ch),
    .sample (sample)
  );

  assign cap_fire = busy && cfg.route && any_ch && adc_vld;

  capstr_addr_gen #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .arm        (cap_arm),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .fire       (cap_fire),
    .busy       (busy),
    .ptr        (ptr),
    .last       (last)
  );

  always_comb begin
    if (cfg.route) begin
      mem_we    = cap_fire;
      mem_addr  = ptr;
      mem_wdata = sample;
    end else begin
      mem_we    = norm_we;
      mem_addr  = norm_addr;
      mem_wdata = norm_wdata;
    end
  end

  assign cap_busy = busy;
  assign cap_done = last;

  // R6: no enabled channel means the routed port never writes
  a_r6_no_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.route && src == SRC_NONE) |-> !mem_we);

  // R2: with routing off the normal strobe reaches the port
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.route |-> (mem_we == norm_we && mem_addr == norm_addr));

  // R8: done only accompanies a real memory write
  a_r8_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> (mem_we && cap_busy));

endmodule

// File: tb/test_capstr_top.sv
module test_capstr_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, soft_rst, ovr_we, cap_arm, adc_vld, norm_we;
  logic [9:0]    ovr_wdata;
  logic [AW-1:0] start_addr, end_addr, norm_addr;
  logic [DW-1:0] adc1_data, adc2_data, norm_wdata;
  logic          mem_we, cap_busy, cap_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  capstr_top #(.AW(AW), .DW(DW)) i_capstr_top (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ovr_we(ovr_we), .ovr_wdata(ovr_wdata), .cap_arm(cap_arm),
    .start_addr(start_addr), .end_addr(end_addr), .adc_vld(adc_vld),
    .adc1_data(adc1_data), .adc2_data(adc2_data),
    .norm_we(norm_we), .norm_addr(norm_addr), .norm_wdata(norm_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cap_busy(cap_busy), .cap_done(cap_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] d1(input int i);
    return DW'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [DW-1:0] d2(input int i);
    return DW'(~(i * 5 + 1));
  endfunction

  task automatic set_ovr(input logic [9:0] v);
    @(negedge clk); ovr_we = 1'b1; ovr_wdata = v;
    @(negedge clk); ovr_we = 1'b0;
  endtask

  task automatic do_arm(input int s, input int e);
    @(negedge clk); start_addr = AW'(s); end_addr = AW'(e); cap_arm = 1'b1;
    @(negedge clk); cap_arm = 1'b0;
  endtask

  // expects to be called just after a negedge with a capture armed
  task automatic run_cap(input int s, input int e, input int sel, input int vmode, input bit rearm);
    int  ea   = s;
    int  nexp = ((e - s) & (NA - 1)) + 1;
    int  n    = 0;
    bit  fin  = 0;
    for (int i = 0; i < 4 * NA && !fin; i++) begin
      adc_vld   = (vmode == 0) ? 1'b1 : (i % 3 != 1);
      adc1_data = d1(i);
      adc2_data = d2(i);
      cap_arm   = rearm && (i == 2);
      if (rearm && i == 2) start_addr = AW'(s + 5);
      #1;
      if (adc_vld) begin
        chk("R3 write per valid", mem_we, 1);
        chk("R7 address", mem_addr, ea & (NA - 1));
        if (sel == 1) chk("R3/R5 ch1 data", mem_wdata, d1(i));
        else          chk("R4 ch2 data", mem_wdata, d2(i));
        chk("R8 done on final write", cap_done, (n == nexp - 1));
        if (rearm) chk("R9 rearm ignored", mem_addr, ea & (NA - 1));
        n++;
        ea  = (ea + 1) & (NA - 1);
        fin = (n == nexp);
      end else begin
        chk("R11 no write without valid", mem_we, 0);
        chk("R11 no done without valid", cap_done, 0);
      end
      @(negedge clk);
    end
    cap_arm = 1'b0;
    adc_vld = 1'b1;
    #1;
    chk("R8 busy cleared", cap_busy, 0);
    chk("R8 no write after end", mem_we, 0);
    chk("R8 write count", n, nexp);
    adc_vld = 1'b0;
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 0; soft_rst = 0; ovr_we = 0; ovr_wdata = '0; cap_arm = 0;
    start_addr = '0; end_addr = '0; adc_vld = 0; adc1_data = '0; adc2_data = '0;
    norm_we = 0; norm_addr = '0; norm_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    norm_we = 1; norm_addr = 4'd9; norm_wdata = 8'h5a; #1;
    chk("R1 busy", cap_busy, 0);
    chk("R1 done", cap_done, 0);
    chk("R1 we follows normal", mem_we, 1);
    chk("R1 addr follows normal", mem_addr, 9);
    chk("R1 data follows normal", mem_wdata, 8'h5a);

    // R2 pass-through patterns
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      norm_we = k[0]; norm_addr = AW'(k * 3); norm_wdata = DW'(k * 37 + 1); #1;
      chk("R2 we", mem_we, k[0]);
      chk("R2 addr", mem_addr, (k * 3) & (NA - 1));
      chk("R2 data", mem_wdata, (k * 37 + 1) & 255);
    end
    norm_we = 0;

    // R3/R7/R8/R11 sweep over start points, lengths and wrap
    set_ovr(10'h101);
    for (int s = 0; s < NA; s++) begin
      do_arm(s, (s + (s % 5) * 3) & (NA - 1));
      run_cap(s, (s + (s % 5) * 3) & (NA - 1), 1, s % 2, 0);
    end
    do_arm(14, 1);  run_cap(14, 1, 1, 0, 0);
    do_arm(6, 5);   run_cap(6, 5, 1, 1, 0);

    // R4 channel 2 only
    set_ovr(10'h201);
    do_arm(3, 7);   run_cap(3, 7, 2, 1, 0);

    // R5 both channels
    set_ovr(10'h301);
    do_arm(10, 12); run_cap(10, 12, 1, 0, 0);

    // R9 rearm while busy
    set_ovr(10'h101);
    do_arm(0, 6);   run_cap(0, 6, 1, 0, 1);

    // R6 no channel: pending, no writes, address held
    set_ovr(10'h001);
    do_arm(4, 6);
    for (int k = 0; k < 5; k++) begin
      adc_vld = 1; adc1_data = d1(k); #1;
      chk("R6 no write", mem_we, 0);
      chk("R6 still busy", cap_busy, 1);
      @(negedge clk);
    end
    adc_vld = 0;
    set_ovr(10'h101);
    run_cap(4, 6, 1, 0, 0);

    // R10 soft reset cancels capture and clears routing
    do_arm(0, 9);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    norm_we = 1; norm_addr = 4'd3; norm_wdata = 8'h77; adc_vld = 1; #1;
    chk("R10 busy cleared", cap_busy, 0);
    chk("R10 route cleared we", mem_we, 1);
    chk("R10 route cleared addr", mem_addr, 3);
    chk("R10 route cleared data", mem_wdata, 8'h77);
    chk("R10 no done", cap_done, 0);
    adc_vld = 0; norm_we = 0;

    @(negedge clk);
    finish_up();
  end

endmodule